// File: doc/BRIEF.md
# Data Memory Effective Address Generator

This block forms the 16-bit data-memory address for an 8-bit microcontroller core. The decoder hands it an addressing-mode code, up to two operand bytes, the current X index register, the direct-page select flag and the RAM page register. One clock after a start pulse it presents the address with a valid strobe. For the auto-increment mode it also returns the next X value with a one-cycle write-enable, so the register file can update X.

Direct-page modes take their high address byte from the page selection. When the flag is clear this is page 0. When the flag is set it is the page register. The low byte comes from X, or from an offset plus X, and that sum wraps inside the page. Absolute mode uses the operand pair as given. An unknown mode code raises an error strobe in place of an address.

The control is a three-state machine:
- `ST_IDLE` is the state with nothing presented.
- `ST_ISSUE` presents the address.
- `ST_FAULT` presents the mode error.

Transitions are taken at every clock edge, whatever the current state:
- `start` with a legal code leads to `ST_ISSUE` (issue).
- `start` with an unknown code leads to `ST_FAULT` (reject).
- No `start` leads to `ST_IDLE` (retire).

Back-to-back starts are therefore accepted on every cycle.

Top module: `dm_ea_gen`

## Requirements
- R1: Mode codes on `mode`: 98h is absolute, D4h is X-indexed direct page, DBh is X-indexed direct page with post-increment, C6h is offset plus X in the direct page. Every other code is illegal.
- R2: In absolute mode `ea` = {`op_hi`, `op_lo`}, whatever `dp_sel` and `page_reg` hold.
- R3: For the three direct-page modes, the high byte of `ea` is 00h when `dp_sel`=0 and `page_reg` when `dp_sel`=1.
- R4: In mode D4h the low byte of `ea` is `x_in`.
- R5: In mode DBh the low byte of `ea` is `x_in` before the increment. `x_out` = (`x_in`+1) mod 256, so FFh becomes 00h, and `x_we` is high for that one result cycle.
- R6: In mode C6h the low byte of `ea` is (`op_lo` + `x_in`) mod 256. The carry is dropped.
- R7: `ea` and `ea_valid` appear exactly one clock after a `start` with a legal code. `ea_valid` is low in any cycle not preceded by such a start.
- R8: A start with an illegal code raises `mode_err` for one cycle. It gives no `ea_valid` and no `x_we`.
- R9: `x_we` is high only in the result cycle of a mode-DBh start.
- R10: While and after reset, before any start, `ea_valid`, `x_we`, `mode_err`, `ea` and `x_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an address computation this cycle |
| mode | input | 8 | Addressing-mode code |
| op_lo | input | 8 | First operand byte (offset, or absolute low byte) |
| op_hi | input | 8 | Second operand byte (absolute high byte) |
| x_in | input | 8 | Current X index register |
| dp_sel | input | 1 | Direct page select: 0 = page 0, 1 = page register |
| page_reg | input | 8 | RAM page register |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Effective address valid |
| x_out | output | 8 | Incremented X value |
| x_we | output | 1 | X write-enable (post-increment) |
| mode_err | output | 1 | Illegal mode code seen |

## Verification
Every result of this block is due exactly one clock after the start pulse that asked for it. This holds for the address, the valid strobe, the new X value with its write-enable, and the mode error. The driver task applies each request on a falling edge and pushes its expected result into a queue. The monitor wakes shortly after each rising edge. If `start` was high at that edge, it pops one item and compares every output with it. Otherwise it requires the valid, error and write-enable strobes to be low. Back-to-back requests are checked with the same one-cycle spacing.

// File: rtl/dm_ea_pkg.sv
package dm_ea_pkg;
    localparam int unsigned DW = 8;
    localparam int unsigned AW = 2 * DW;

    localparam logic [DW-1:0] CODE_ABS  = 8'h98;
    localparam logic [DW-1:0] CODE_XDP  = 8'hD4;
    localparam logic [DW-1:0] CODE_XINC = 8'hDB;
    localparam logic [DW-1:0] CODE_XOFS = 8'hC6;

    typedef enum logic [1:0] {
        AM_ABS  = 2'd0,
        AM_XDP  = 2'd1,
        AM_XINC = 2'd2,
        AM_XOFS = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } fsm_e;
endpackage

// File: rtl/dm_ea_decode.sv
module dm_ea_decode
    import dm_ea_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] code,
    output amode_e       am,
    output logic         legal
);
    always_comb begin
        am    = AM_ABS;
        legal = 1'b1;
        case (code)
            CODE_ABS:  am = AM_ABS;
            CODE_XDP:  am = AM_XDP;
            CODE_XINC: am = AM_XINC;
            CODE_XOFS: am = AM_XOFS;
            default:   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/dm_ea_calc.sv
module dm_ea_calc
    import dm_ea_pkg::*;
#(
    parameter int unsigned W = DW,
    localparam int unsigned A = 2 * W
) (
    input  amode_e       am,
    input  logic [W-1:0] op_lo,
    input  logic [W-1:0] op_hi,
    input  logic [W-1:0] x_cur,
    input  logic         dp_sel,
    input  logic [W-1:0] page_reg,
    output logic [A-1:0] addr,
    output logic [W-1:0] x_nxt,
    output logic         inc
);
    logic [W-1:0] page_hi;
    logic [W-1:0] ofs_sum;

    assign page_hi = dp_sel ? page_reg : '0;
    assign ofs_sum = op_lo + x_cur;
    assign x_nxt   = x_cur + {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        inc = 1'b0;
        unique case (am)
            AM_ABS:  addr = {op_hi, op_lo};
            AM_XDP:  addr = {page_hi, x_cur};
            AM_XINC: begin
                addr = {page_hi, x_cur};
                inc  = 1'b1;
            end
            AM_XOFS: addr = {page_hi, ofs_sum};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/dm_ea_gen.sv
module dm_ea_gen
    import dm_ea_pkg::*;
#(
    parameter int unsigned W = DW,
    localparam int unsigned A = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] op_lo,
    input  logic [W-1:0] op_hi,
    input  logic [W-1:0] x_in,
    input  logic         dp_sel,
    input  logic [W-1:0] page_reg,
    output logic [A-1:0] ea,
    output logic         ea_valid,
    output logic [W-1:0] x_out,
    output logic         x_we,
    output logic         mode_err
);
    amode_e       am;
    logic         legal;
    logic [A-1:0] addr_c;
    logic [W-1:0] xn_c;
    logic         inc_c;

    fsm_e         state_q, state_d;
    logic [A-1:0] ea_q;
    logic [W-1:0] x_q;
    logic         inc_q;

    dm_ea_decode #(.W(W)) u_dec (
        .code  (mode),
        .am    (am),
        .legal (legal)
    );

    dm_ea_calc #(.W(W)) u_calc (
        .am       (am),
        .op_lo    (op_lo),
        .op_hi    (op_hi),
        .x_cur    (x_in),
        .dp_sel   (dp_sel),
        .page_reg (page_reg),
        .addr     (addr_c),
        .x_nxt    (xn_c),
        .inc      (inc_c)
    );

    // next-state: identical from every state (issue / reject / retire)
    always_comb begin
        if (start && legal)
            state_d = ST_ISSUE;
        else if (start)
            state_d = ST_FAULT;
        else
            state_d = ST_IDLE;
    end

    // state and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
            x_q     <= '0;
            inc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start && legal) begin
                ea_q  <= addr_c;
                inc_q <= inc_c;
                if (inc_c)
                    x_q <= xn_c;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        ea       = ea_q;
        x_out    = x_q;
        ea_valid = 1'b0;
        x_we     = 1'b0;
        mode_err = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                ea_valid = 1'b1;
                x_we     = inc_q;
            end
            ST_FAULT: mode_err = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/dm_ea_chk.sv
module dm_ea_chk
    import dm_ea_pkg::*;
#(
    parameter int unsigned W = DW,
    localparam int unsigned A = 2 * W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] mode,
    input logic [W-1:0] op_lo,
    input logic [W-1:0] op_hi,
    input logic [W-1:0] x_in,
    input logic [A-1:0] ea,
    input logic         ea_valid,
    input logic [W-1:0] x_out,
    input logic         x_we,
    input logic         mode_err
);
    assert_abs_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == CODE_ABS) |=> (ea_valid && ea == {$past(op_hi), $past(op_lo)}));

    assert_inc_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        x_we |-> (x_out == W'($past(x_in) + 1'b1)));

    assert_valid_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> $past(start));

    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!ea_valid && !x_we));

    assert_we_only_xinc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        x_we |-> ($past(start) && $past(mode) == CODE_XINC));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ea_valid, mode_err}));
endmodule

bind dm_ea_gen dm_ea_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .op_lo    (op_lo),
    .op_hi    (op_hi),
    .x_in     (x_in),
    .ea       (ea),
    .ea_valid (ea_valid),
    .x_out    (x_out),
    .x_we     (x_we),
    .mode_err (mode_err)
);

// File: tb/dm_ea_gen_tb_top.sv
`timescale 1ns/1ps
module dm_ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mode = '0, op_lo = '0, op_hi = '0, x_in = '0, page_reg = '0;
    logic        dp_sel = 1'b0;
    logic [15:0] ea;
    logic        ea_valid, x_we, mode_err;
    logic [7:0]  x_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] ea;
        logic        valid;
        logic        we;
        logic [7:0]  xv;
        logic        err;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    dm_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_lo(op_lo), .op_hi(op_hi), .x_in(x_in), .dp_sel(dp_sel),
        .page_reg(page_reg), .ea(ea), .ea_valid(ea_valid), .x_out(x_out),
        .x_we(x_we), .mode_err(mode_err)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] m, input logic [7:0] lo,
                                   input logic [7:0] hi, input logic [7:0] x,
                                   input logic g, input logic [7:0] pg, input string tag);
        exp_t e;
        logic [7:0] ph;
        ph = g ? pg : 8'h00;
        e.valid = 1'b1; e.we = 1'b0; e.err = 1'b0; e.xv = 8'h00; e.ea = 16'h0; e.tag = tag;
        case (m)
            8'h98: e.ea = {hi, lo};
            8'hD4: e.ea = {ph, x};
            8'hDB: begin e.ea = {ph, x}; e.we = 1'b1; e.xv = x + 8'h01; end
            8'hC6: e.ea = {ph, 8'(lo + x)};
            default: begin e.valid = 1'b0; e.err = 1'b1; end
        endcase
        return e;
    endfunction

    // driver: apply on falling edge, push expectation
    task automatic issue(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic g, input logic [7:0] pg,
                         input string tag);
        @(negedge clk);
        start = 1'b1; mode = m; op_lo = lo; op_hi = hi; x_in = x; dp_sel = g; page_reg = pg;
        q.push_back(model(m, lo, hi, x, g, pg, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // monitor: result is due one clock after the edge that saw start
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (start) begin
                    exp_t e;
                    if (q.size() == 0) begin
                        check(1'b0, "R7 queue", "empty", "item");
                    end else begin
                        e = q.pop_front();
                        check(ea_valid == e.valid, {e.tag, " valid"},
                              $sformatf("%0b", ea_valid), $sformatf("%0b", e.valid));
                        check(mode_err == e.err, {e.tag, " R8 err"},
                              $sformatf("%0b", mode_err), $sformatf("%0b", e.err));
                        check(x_we == e.we, {e.tag, " R9 x_we"},
                              $sformatf("%0b", x_we), $sformatf("%0b", e.we));
                        if (e.valid)
                            check(ea == e.ea, {e.tag, " ea"},
                                  $sformatf("%h", ea), $sformatf("%h", e.ea));
                        if (e.we)
                            check(x_out == e.xv, {e.tag, " R5 x_out"},
                                  $sformatf("%h", x_out), $sformatf("%h", e.xv));
                    end
                end else begin
                    check(!ea_valid && !mode_err && !x_we, "R7 idle strobes",
                          $sformatf("%b%b%b", ea_valid, mode_err, x_we), "000");
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        check(1'b0, "watchdog", "timeout", "finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check(ea == 16'h0 && x_out == 8'h0 && !ea_valid && !x_we && !mode_err,
              "R10 reset", $sformatf("%h %h %b%b%b", ea, x_out, ea_valid, x_we, mode_err), "0000 00 000");
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        #1;
        check(ea == 16'h0 && !ea_valid, "R10 after reset", $sformatf("%h %b", ea, ea_valid), "0000 0");

        // R2: absolute ignores page select
        issue(8'h98, 8'h15, 8'h01, 8'hAA, 1'b1, 8'h7E, "R2 abs g1");
        idle(1);
        issue(8'h98, 8'h34, 8'h12, 8'h00, 1'b0, 8'h55, "R2 abs g0");
        idle(1);
        // R4 and R3: X-indexed, both page selections
        issue(8'hD4, 8'h00, 8'h00, 8'h15, 1'b1, 8'h01, "R4 R3 xdp g1");
        idle(1);
        issue(8'hD4, 8'h99, 8'h88, 8'hC3, 1'b0, 8'h42, "R4 R3 xdp g0");
        idle(1);
        // R5: post-increment and its wrap
        issue(8'hDB, 8'h00, 8'h00, 8'h35, 1'b0, 8'h10, "R5 xinc");
        idle(1);
        issue(8'hDB, 8'h00, 8'h00, 8'hFF, 1'b1, 8'h02, "R5 xinc wrap");
        idle(1);
        // R6: offset plus X, carry dropped
        issue(8'hC6, 8'h45, 8'h00, 8'hF5, 1'b0, 8'h09, "R6 ofs wrap");
        idle(1);
        issue(8'hC6, 8'h10, 8'h00, 8'h20, 1'b1, 8'h03, "R6 R3 ofs g1");
        idle(1);
        // R8/R1: illegal codes
        issue(8'h00, 8'h11, 8'h22, 8'h33, 1'b1, 8'h44, "R1 R8 bad 00");
        idle(1);
        issue(8'hD5, 8'h11, 8'h22, 8'h33, 1'b0, 8'h44, "R1 R8 bad D5");
        idle(1);
        // R7: back-to-back mixed stream
        issue(8'hDB, 8'h00, 8'h00, 8'h7F, 1'b1, 8'hE0, "R7 b2b xinc");
        issue(8'h98, 8'hCD, 8'hAB, 8'h00, 1'b0, 8'h00, "R7 b2b abs");
        issue(8'hFF, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00, "R7 b2b bad");
        issue(8'hC6, 8'hFF, 8'h00, 8'h01, 1'b1, 8'h80, "R7 b2b ofs");
        issue(8'hD4, 8'h00, 8'h00, 8'h5A, 1'b1, 8'hFF, "R7 b2b xdp");
        idle(3);
        // sweep of offsets
        for (int k = 0; k < 16; k++) begin
            issue(8'hC6, 8'(k * 17), 8'h00, 8'(255 - k * 5), k[0], 8'(k + 1), "R6 sweep");
        end
        idle(3);
        check(q.size() == 0, "R7 drained", $sformatf("%0d", q.size()), "0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule